// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits beside a memory controller's ECC checker and records the errors it reports. The checker raises a one-cycle pulse for a correctable or an uncorrectable error, together with the physical address of the access, the 8-bit syndrome and the channel that returned the data. The block sets a sticky flag for each error class. It also keeps the address, syndrome and channel of one logged error, so that software can find the failing location later.

Only one set of capture registers exists, so a priority rule decides which error they describe. The first error after an empty log is kept. A later correctable error never disturbs it. An uncorrectable error replaces a logged correctable error, because its location matters more. Software reads the registers through a plain byte-addressed read/write port and clears the flags by writing ones. An enable register selects which classes drive a registered alert line.

Register map (byte addresses, word aligned; the low two address bits are ignored; unmapped words read as zero): 0x00 status, 0x04 alert enable, 0x08 captured address, 0x0C syndrome and channel.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `alert_o` is low.
- R2: With both flags clear, a correctable pulse sets status bit 0 and loads the capture registers. The address register reads bits 31:12 of the event address in bits 31:12, and bits 11:0 read zero. The syndrome reads in bits 7:0 at 0x0C.
- R3: With both flags clear, an uncorrectable pulse sets status bit 7 and loads the capture registers.
- R4: A correctable pulse that arrives while either flag is set leaves the address, syndrome and channel unchanged, and it sets status bit 0.
- R5: An uncorrectable pulse that arrives while only the correctable flag is set overwrites the address, syndrome and channel. Afterwards both flags are set.
- R6: An uncorrectable pulse that arrives while the uncorrectable flag is already set leaves the capture registers unchanged.
- R7: Correctable and uncorrectable pulses in the same cycle are handled as an uncorrectable error, and both status bits become set.
- R8: Writing 1 to status bit 0 or bit 7 clears that flag, and writing 0 leaves it unchanged. All other status bits read zero, whatever is written to them.
- R9: Once both flags have been cleared, the next error of either class loads the capture registers.
- R10: An error pulse that arrives in the same cycle as a clearing write to its own flag wins. The flag stays set, and the capture registers follow the rules as if the clear had already taken place.
- R11: In the enable register only bit 7 (correctable) and bit 8 (uncorrectable) can be written. All other bits read zero.
- R12: `alert_o` is the OR over both classes of (flag AND its enable bit), registered once. It therefore follows the register contents one cycle later.
- R13: The channel of the logged error reads in bit 8 at 0x0C, which is bit 0 of byte 0x0D. Bits 15:9 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt_i | input | 1 | Correctable error pulse |
| ue_evt_i | input | 1 | Uncorrectable error pulse |
| evt_addr_i | input | 32 | Physical address of the erroneous access |
| evt_syn_i | input | 8 | ECC syndrome of the event |
| evt_chan_i | input | 1 | Channel that took the error |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from the address) |
| alert_o | output | 1 | Registered alert line |

## Verification
The directed corner cases are a correctable error on top of a logged one, an uncorrectable error replacing a correctable one, a second uncorrectable error, simultaneous pulses, and a clearing write that coincides with a new error. A design that gets these wrong either shows the address of the wrong error, or loses a flag that was set in the very cycle software cleared it. The random phase mixes pulses, partial clears and enable writes against a reference model, to catch ordering mistakes between clearing and capture. It also catches an alert line that runs a cycle early or late against the flags and the enables.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int DATA_W = 32;
    localparam int REG_AW = 8;
    localparam int WORD_AW = REG_AW - 2;

    // word indices of the register map
    localparam logic [WORD_AW-1:0] WA_STATUS = 6'd0;
    localparam logic [WORD_AW-1:0] WA_ENABLE = 6'd1;
    localparam logic [WORD_AW-1:0] WA_ADDR   = 6'd2;
    localparam logic [WORD_AW-1:0] WA_SYNCH  = 6'd3;

    // bit positions software depends on
    localparam int ST_CE   = 0;
    localparam int ST_UE   = 7;
    localparam int EN_CE   = 7;
    localparam int EN_UE   = 8;
    localparam int CHAN_BIT = 8;

    typedef struct packed {
        logic ue;
        logic ce;
    } cls_pair_t;
endpackage

// File: rtl/ecc_capture.sv
module ecc_capture
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 12,
    parameter int SYN_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce_i,
    input  logic                      ue_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [SYN_W-1:0]          syn_i,
    input  logic                      chan_i,
    input  cls_pair_t                 clr_i,
    output cls_pair_t                 flag_o,
    output logic [ADDR_W-BLK_SHIFT-1:0] cap_blk_o,
    output logic [SYN_W-1:0]          cap_syn_o,
    output logic                      cap_chan_o
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    typedef struct packed {
        cls_pair_t          flag;
        logic [BLK_W-1:0]   blk;
        logic [SYN_W-1:0]   syn;
        logic               chan;
    } cap_state_t;

    cap_state_t st_d, st_q;
    cls_pair_t  kept;
    logic       load;

    always_comb begin
        st_d = st_q;
        // flags surviving this cycle's clear
        kept.ce = st_q.flag.ce & ~clr_i.ce;
        kept.ue = st_q.flag.ue & ~clr_i.ue;
        if (ue_i)
            load = ~kept.ue;
        else
            load = ce_i & ~kept.ce & ~kept.ue;
        st_d.flag.ce = kept.ce | ce_i;
        st_d.flag.ue = kept.ue | ue_i;
        if (load) begin
            st_d.blk  = addr_i[ADDR_W-1:BLK_SHIFT];
            st_d.syn  = syn_i;
            st_d.chan = chan_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o     = st_q.flag;
    assign cap_blk_o  = st_q.blk;
    assign cap_syn_o  = st_q.syn;
    assign cap_chan_o = st_q.chan;

    p_ue_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ue_i |=> flag_o.ue);
    p_ce_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !ue_i && !clr_i.ce && !clr_i.ue && (flag_o.ce || flag_o.ue))
        |=> ($stable(cap_blk_o) && $stable(cap_syn_o) && $stable(cap_chan_o)));
    p_ue_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_i && !flag_o.ue) |=> (cap_blk_o == $past(addr_i[ADDR_W-1:BLK_SHIFT])
                                   && cap_syn_o == $past(syn_i)));
    p_ue_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_i && flag_o.ue && !clr_i.ue) |=> $stable(cap_blk_o));
    p_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && ue_i) |=> (flag_o.ce && flag_o.ue));
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o.ce && !clr_i.ce) |=> flag_o.ce);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i.ce && !ce_i) |=> !flag_o.ce);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i.ue && ue_i) |=> flag_o.ue);
endmodule

// File: rtl/ecc_regif.sv
module ecc_regif
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 12,
    parameter int SYN_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_AW-1:0]           reg_addr_i,
    input  logic                        reg_wr_i,
    input  logic [DATA_W-1:0]           reg_wdata_i,
    input  cls_pair_t                   flag_i,
    input  logic [ADDR_W-BLK_SHIFT-1:0] cap_blk_i,
    input  logic [SYN_W-1:0]            cap_syn_i,
    input  logic                        cap_chan_i,
    output cls_pair_t                   clr_o,
    output cls_pair_t                   en_o,
    output logic [DATA_W-1:0]           reg_rdata_o
);
    typedef struct packed {
        cls_pair_t en;
    } rif_state_t;

    rif_state_t st_d, st_q;
    logic [WORD_AW-1:0] widx;

    assign widx = reg_addr_i[REG_AW-1:2];

    always_comb begin
        st_d = st_q;
        clr_o = '0;
        if (reg_wr_i && widx == WA_STATUS) begin
            clr_o.ce = reg_wdata_i[ST_CE];
            clr_o.ue = reg_wdata_i[ST_UE];
        end
        if (reg_wr_i && widx == WA_ENABLE) begin
            st_d.en.ce = reg_wdata_i[EN_CE];
            st_d.en.ue = reg_wdata_i[EN_UE];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    always_comb begin
        reg_rdata_o = '0;
        case (widx)
            WA_STATUS: begin
                reg_rdata_o[ST_CE] = flag_i.ce;
                reg_rdata_o[ST_UE] = flag_i.ue;
            end
            WA_ENABLE: begin
                reg_rdata_o[EN_CE] = st_q.en.ce;
                reg_rdata_o[EN_UE] = st_q.en.ue;
            end
            WA_ADDR:   reg_rdata_o[ADDR_W-1:BLK_SHIFT] = cap_blk_i;
            WA_SYNCH: begin
                reg_rdata_o[SYN_W-1:0] = cap_syn_i;
                reg_rdata_o[CHAN_BIT]  = cap_chan_i;
            end
            default:   reg_rdata_o = '0;
        endcase
    end

    p_en_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && widx == WA_ENABLE) |=> (en_o.ce == $past(reg_wdata_i[EN_CE])
                                            && en_o.ue == $past(reg_wdata_i[EN_UE])));
    p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && widx == WA_ENABLE) |=> $stable(en_o));
    p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (widx == WA_ADDR) |-> (reg_rdata_o[BLK_SHIFT-1:0] == '0));
endmodule

// File: rtl/ecc_alert.sv
module ecc_alert
    import ecc_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cls_pair_t flag_i,
    input  cls_pair_t en_i,
    output logic      alert_o
);
    typedef struct packed {
        logic alert;
    } al_state_t;

    al_state_t st_d, st_q;

    always_comb begin
        st_d.alert = (flag_i.ce & en_i.ce) | (flag_i.ue & en_i.ue);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alert_o = st_q.alert;

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_i.ce && !flag_i.ue) |=> !alert_o);
    p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i.ce && !en_i.ue) |=> !alert_o);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 12,
    parameter int SYN_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_evt_i,
    input  logic              ue_evt_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic [SYN_W-1:0]  evt_syn_i,
    input  logic              evt_chan_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              alert_o
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    cls_pair_t        flag, clr, en;
    logic [BLK_W-1:0] cap_blk;
    logic [SYN_W-1:0] cap_syn;
    logic             cap_chan;

    ecc_capture #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SYN_W(SYN_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .ce_i(ce_evt_i), .ue_i(ue_evt_i),
        .addr_i(evt_addr_i), .syn_i(evt_syn_i), .chan_i(evt_chan_i),
        .clr_i(clr), .flag_o(flag),
        .cap_blk_o(cap_blk), .cap_syn_o(cap_syn), .cap_chan_o(cap_chan)
    );

    ecc_regif #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SYN_W(SYN_W)) u_rif (
        .clk(clk), .rst_n(rst_n),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .flag_i(flag), .cap_blk_i(cap_blk), .cap_syn_i(cap_syn), .cap_chan_i(cap_chan),
        .clr_o(clr), .en_o(en), .reg_rdata_o(reg_rdata_o)
    );

    ecc_alert u_alert (
        .clk(clk), .rst_n(rst_n),
        .flag_i(flag), .en_i(en), .alert_o(alert_o)
    );
endmodule

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/100ps
module sim_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt, ue_evt, evt_chan;
    logic [31:0] evt_addr;
    logic [7:0]  evt_syn;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        alert;

    int nchk = 0;
    int nerr = 0;

    // reference model
    logic        m_ce, m_ue, m_en_ce, m_en_ue, m_chan, m_alert;
    logic [19:0] m_blk;
    logic [7:0]  m_syn;

    ecc_err_log u0 (
        .clk(clk), .rst_n(rst_n),
        .ce_evt_i(ce_evt), .ue_evt_i(ue_evt),
        .evt_addr_i(evt_addr), .evt_syn_i(evt_syn), .evt_chan_i(evt_chan),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .alert_o(alert)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        case (a[7:2])
            6'd0: exp_word = {24'd0, m_ue, 6'd0, m_ce};
            6'd1: exp_word = {23'd0, m_en_ue, m_en_ce, 7'd0};
            6'd2: exp_word = {m_blk, 12'd0};
            6'd3: exp_word = {23'd0, m_chan, m_syn};
            default: exp_word = 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // called with the clock low; checks every register against the model
    task automatic check_all(input string tag);
        logic [31:0] d;
        chk({tag, " R12 alert"}, {31'd0, alert}, {31'd0, m_alert});
        rd(8'h00, d); chk({tag, " R8 status"}, d, exp_word(8'h00));
        rd(8'h04, d); chk({tag, " R11 enable"}, d, exp_word(8'h04));
        rd(8'h08, d); chk({tag, " R2 address"}, d, exp_word(8'h08));
        rd(8'h0D, d); chk({tag, " R13 syn/chan"}, d, exp_word(8'h0C));
    endtask

    task automatic step(input logic ce, input logic ue, input logic [31:0] a,
                        input logic [7:0] s, input logic ch, input logic wr,
                        input logic [7:0] wa, input logic [31:0] wd);
        logic kc, ku, load;
        ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = ch;
        reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        m_alert = (m_ce & m_en_ce) | (m_ue & m_en_ue);
        kc = m_ce & ~(wr && wa[7:2] == 6'd0 && wd[0]);
        ku = m_ue & ~(wr && wa[7:2] == 6'd0 && wd[7]);
        load = ue ? ~ku : (ce & ~kc & ~ku);
        m_ce = kc | ce;
        m_ue = ku | ue;
        if (load) begin m_blk = a[31:12]; m_syn = s; m_chan = ch; end
        if (wr && wa[7:2] == 6'd1) begin m_en_ce = wd[7]; m_en_ue = wd[8]; end
        @(negedge clk);
        ce_evt = 0; ue_evt = 0; reg_wr = 0;
    endtask

    task automatic idle();
        step(0, 0, 32'd0, 8'd0, 0, 0, 8'h00, 32'd0);
    endtask

    initial begin : watchdog
        #1500000;
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd20240611));
        ce_evt = 0; ue_evt = 0; evt_addr = 0; evt_syn = 0; evt_chan = 0;
        reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        {m_ce, m_ue, m_en_ce, m_en_ue, m_chan, m_alert} = '0;
        m_blk = '0; m_syn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check_all("R1 reset");

        // R2: CE into an empty log
        step(1, 0, 32'hDEAD_BFFF, 8'h5A, 1, 0, 8'h00, 0);
        rd(8'h08, d); chk("R2 CE loads address, low bits zero", d, 32'hDEAD_B000);
        rd(8'h0C, d); chk("R13 channel in bit 8", d, 32'h0000_015A);
        check_all("R2");
        // R4: second CE leaves capture alone
        step(1, 0, 32'h1111_1111, 8'h22, 0, 0, 8'h00, 0);
        rd(8'h08, d); chk("R4 CE over logged CE keeps address", d, 32'hDEAD_B000);
        check_all("R4");
        // R5: UE overwrites CE
        step(0, 1, 32'h4444_4444, 8'h99, 0, 0, 8'h00, 0);
        rd(8'h08, d); chk("R5 UE overwrites CE address", d, 32'h4444_4000);
        rd(8'h00, d); chk("R5 both flags", d, 32'h81);
        // R6: UE over UE keeps first
        step(0, 1, 32'h7777_7777, 8'h33, 1, 0, 8'h00, 0);
        rd(8'h0C, d); chk("R6 UE over UE keeps syndrome", d, 32'h99);
        // R8: w1c
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'h0000_0001);
        rd(8'h00, d); chk("R8 clear CE only", d, 32'h80);
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'hFFFF_FF7E);
        rd(8'h00, d); chk("R8 zeros leave UE set", d, 32'h80);
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'h0000_0080);
        rd(8'h00, d); chk("R8 clear UE", d, 32'h0);
        // R9: next CE loads after full clear
        step(1, 0, 32'hABCD_E123, 8'h0F, 0, 0, 8'h00, 0);
        rd(8'h08, d); chk("R9 reload after clear", d, 32'hABCD_E000);
        // R10: clear and CE in same cycle
        step(1, 0, 32'h1357_9BDF, 8'hC3, 1, 1, 8'h00, 32'h1);
        rd(8'h00, d); chk("R10 flag survives clear", d, 32'h1);
        rd(8'h08, d); chk("R10 capture reloaded", d, 32'h1357_9000);
        // R7: both pulses together
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'h81);
        step(1, 1, 32'h0246_8ACE, 8'h77, 0, 0, 8'h00, 0);
        rd(8'h00, d); chk("R7 both flags set", d, 32'h81);
        rd(8'h0C, d); chk("R7 syndrome of event", d, 32'h77);
        // R3: UE into empty log
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'h81);
        step(0, 1, 32'hF000_0FFF, 8'hE1, 1, 0, 8'h00, 0);
        rd(8'h00, d); chk("R3 UE flag", d, 32'h80);
        rd(8'h08, d); chk("R3 UE address", d, 32'hF000_0000);
        // R11/R12
        step(0, 0, 0, 0, 0, 1, 8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R11 only two enable bits", d, 32'h180);
        chk("R12 alert not yet", {31'd0, alert}, 32'd0);
        idle();
        chk("R12 alert one cycle after enable", {31'd0, alert}, 32'd1);
        step(0, 0, 0, 0, 0, 1, 8'h04, 32'h0000_0080);
        idle();
        chk("R12 UE masked", {31'd0, alert}, 32'd0);
        check_all("R12");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic ce, ue, wr;
            logic [7:0] wa;
            r = $urandom;
            ce = (r[3:0] == 4'd0);
            ue = (r[7:4] == 4'd0);
            wr = (r[10:8] == 3'd0);
            wa = r[11] ? 8'h04 : 8'h00;
            step(ce, ue, $urandom, r[31:24], r[12], wr, wa, $urandom);
            check_all("RND");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule